// File: doc/BRIEF.md
# TDM-8 Serial Audio Port

A slave-mode serial port for time-division-multiplexed audio. Each frame carries eight 32-bit slots. An external device supplies the bit clock and the frame sync. Both are sampled in a faster system clock domain, and their edges are detected there. The receive side collects the serial input into 32-bit words and pushes one word per slot into a receive FIFO. The transmit side pops one word per slot from a transmit FIFO and shifts it out MSB first.

Shifting happens on detected rising edges of the bit clock. The per-word work happens on the falling edge that follows the last bit of a word. At that point the received word is pushed first, and the transmit register is reloaded one system cycle later. The reload is armed only by the rising edge that shifted out the last bit, so no bit of the next word is lost. A slot counter gives the word position in the frame.

The block also drives a frame marker together with the serial output. Both leave through one shared delay line, so the two stay aligned. The host writes words to be sent and reads received words through plain valid/ready FIFO ports.

Top module: `tdm_port`

## Requirements
- R1: Input bits are sampled on bit-clock rising edges. The first rise after the rise that sees frame sync high carries bit 31 of slot 0. Each 32 sampled bits form one word, MSB first, and words are pushed to the receive FIFO one per slot in arrival order.
- R2: Each slot's transmit word is popped from the transmit FIFO in push order. Bit 31 is on `sdataOut` before the first rise of the slot, and each following rise moves the output to the next lower bit.
- R3: `slotIdx` is 0 after the rise that sees frame sync high. It advances by one after every 32 data rises and returns from 7 to 0 when the next frame sync arrives.
- R4: The transmit reload happens only on the falling edge after the rise that shifted the final bit of a word, one system cycle after the receive push. A continuously sent word such as 0x55555554 therefore appears bit-exact in every slot across frame boundaries.
- R5: If the transmit FIFO is empty at a reload, the slot is sent as all zeros and `txUnderrun` goes high and stays high until reset.
- R6: If the receive FIFO is full at a push, the word is dropped, the words already stored are kept unchanged, and `rxOverrun` goes high and stays high until reset.
- R7: `fsyncOut` (active high) is high for exactly the bit period in which `sdataOut` carries bit 31 of slot 0, and low for every other bit period.
- R8: After reset, `sdataOut`, `fsyncOut`, `slotIdx`, `rxValid`, `txUnderrun` and `rxOverrun` are 0, and `txReady` is 1.
- R9: Each FIFO holds 8 words. `txReady` is low once 8 words are waiting, and a ninth word is not taken.
- R10: Before the first frame sync, no word is pushed to the receive FIFO, no word is taken from the transmit FIFO, and `sdataOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | External bit clock |
| fsyncIn | input | 1 | External frame sync, active high, one bit wide |
| sdataIn | input | 1 | Serial receive data |
| sdataOut | output | 1 | Serial transmit data |
| fsyncOut | output | 1 | Frame marker aligned with sdataOut |
| slotIdx | output | 3 | Current slot position in the frame |
| txValid | input | 1 | Host offers a transmit word |
| txReady | output | 1 | Transmit FIFO has room |
| txData | input | 32 | Transmit word from the host |
| rxValid | output | 1 | Receive FIFO holds a word |
| rxReady | input | 1 | Host takes the receive word |
| rxData | output | 32 | Oldest received word |
| txUnderrun | output | 1 | Sticky: a slot was sent with no word available |
| rxOverrun | output | 1 | Sticky: a received word was dropped |

## Verification
The assertions take for granted that the bit clock is at least four system cycles per phase, so that a detected rise and the next detected fall never fall in the same or adjacent cycles. They also assume that frame sync and input data change only around bit-clock falling edges and are high for one bit. The stimulus runs each bit clock phase for eight system cycles and changes frame sync and data only as it drives the bit clock low. This keeps the synchronized samples of all three inputs in step.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Strobes and sampled bit handed from the control to the datapath
  typedef struct packed {
    logic dataBit;    // synchronized serial input bit
    logic rxShift;    // shift dataBit into the receive register
    logic txShift;    // shift the transmit register one place
    logic pushRx;     // word boundary: push the received word
    logic loadTx;     // word boundary: reload transmit word (after push)
    logic launch;     // update the frame marker in step with loadTx
    logic frameMark;  // frame sync value seen at the last rise
  } tdm_strobe_t;

endpackage

// File: rtl/tdm_fifo.sv
module tdm_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [WIDTH-1:0] outData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign inReady  = (count != CW'(DEPTH));
  assign outValid = (count != '0);
  assign outData  = mem[rdPtr];
  assign doPush   = inValid && inReady;
  assign doPop    = outValid && outReady;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R9: occupancy never exceeds the configured depth
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bclkIn,
  input  logic                     fsyncIn,
  input  logic                     sdataIn,
  output tdm_strobe_t              strb,
  output logic [$clog2(SLOTS)-1:0] slotIdx
);
  localparam int BW = $clog2(WORD_W);
  localparam int SW = $clog2(SLOTS);

  logic [2:0]    bclkSync;   // [1] synchronized, [2] previous
  logic [1:0]    fsSync, dSync;
  logic          rise, fall, wordEnd;
  logic          synced, pushPend, loadPend, loadGo, fallD, fsMark;
  logic [BW-1:0] bitCnt;
  logic [SW-1:0] slotCnt;

  assign rise    = bclkSync[1] && !bclkSync[2];
  assign fall    = !bclkSync[1] && bclkSync[2];
  assign wordEnd = synced && (bitCnt == BW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclkSync <= '0;
      fsSync   <= '0;
      dSync    <= '0;
      synced   <= 1'b0;
      bitCnt   <= '0;
      slotCnt  <= '0;
      pushPend <= 1'b0;
      loadPend <= 1'b0;
      loadGo   <= 1'b0;
      fallD    <= 1'b0;
      fsMark   <= 1'b0;
    end else begin
      bclkSync <= {bclkSync[1:0], bclkIn};
      fsSync   <= {fsSync[0], fsyncIn};
      dSync    <= {dSync[0], sdataIn};
      fallD    <= fall;
      // reload follows the push by one cycle and needs an armed boundary
      loadGo   <= fall && loadPend;
      if (rise) begin
        fsMark <= fsSync[1];
        if (fsSync[1]) begin
          synced  <= 1'b1;
          bitCnt  <= '0;
          slotCnt <= '0;
        end else if (synced) begin
          if (wordEnd) begin
            bitCnt  <= '0;
            slotCnt <= (slotCnt == SW'(SLOTS - 1)) ? '0 : slotCnt + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        if (wordEnd) pushPend <= 1'b1;
        if (wordEnd || fsSync[1]) loadPend <= 1'b1;
      end else if (fall) begin
        pushPend <= 1'b0;
        loadPend <= 1'b0;
      end
    end
  end

  assign strb.dataBit   = dSync[1];
  assign strb.rxShift   = rise && synced;
  assign strb.txShift   = rise;
  assign strb.pushRx    = fall && pushPend;
  assign strb.loadTx    = loadGo;
  assign strb.launch    = fallD;
  assign strb.frameMark = fsMark;
  assign slotIdx        = slotCnt;

  // R3: the slot position only moves in response to a rising bit-clock edge
  a_r3_slot_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slotCnt) |-> $past(rise));

  // R4: a receive push is always followed by the transmit reload
  a_r4_push_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pushRx |=> strb.loadTx);

  // R4: a reload is only issued right after a detected falling edge
  a_r4_load_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadTx |-> $past(fall));

  // R10: nothing is pushed before the first frame sync
  a_r10_no_push_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !strb.pushRx);

endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int OUT_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tdm_strobe_t       strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txAvail,
  output logic              txTake,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush,
  input  logic              rxRoom,
  output logic              sdataOut,
  output logic              fsyncOut,
  output logic              txUnderrun,
  output logic              rxOverrun
);
  logic [WORD_W-1:0] rxShreg, txShreg;
  logic              fsLaunch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShreg    <= '0;
      txShreg    <= '0;
      fsLaunch   <= 1'b0;
      txUnderrun <= 1'b0;
      rxOverrun  <= 1'b0;
    end else begin
      if (strb.rxShift) rxShreg <= {rxShreg[WORD_W-2:0], strb.dataBit};
      if (strb.loadTx) txShreg <= txAvail ? txWord : '0;
      else if (strb.txShift) txShreg <= {txShreg[WORD_W-2:0], 1'b0};
      if (strb.loadTx && !txAvail) txUnderrun <= 1'b1;
      if (strb.pushRx && !rxRoom) rxOverrun <= 1'b1;
      if (strb.launch) fsLaunch <= strb.frameMark;
    end
  end

  assign txTake = strb.loadTx && txAvail;
  assign rxPush = strb.pushRx;
  assign rxWord = rxShreg;

  // marker and data share one delay line so they leave aligned
  generate
    if (OUT_DLY == 0) begin : g_direct
      assign sdataOut = txShreg[WORD_W-1];
      assign fsyncOut = fsLaunch;
    end else begin : g_pipe
      logic [1:0] stage [OUT_DLY];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < OUT_DLY; i++) stage[i] <= '0;
        end else begin
          stage[0] <= {fsLaunch, txShreg[WORD_W-1]};
          for (int i = 1; i < OUT_DLY; i++) stage[i] <= stage[i-1];
        end
      end
      assign {fsyncOut, sdataOut} = stage[OUT_DLY-1];
    end
  endgenerate

  // R5: underrun flag is sticky
  a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    txUnderrun |=> txUnderrun);

  // R5: a reload with no word available leaves an all-zero register
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadTx && !txAvail) |=> (txShreg == '0));

  // R6: overrun flag is sticky
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rxOverrun |=> rxOverrun);

  // R2: a reload puts the popped word's MSB at the serial tap
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadTx && txAvail) |=> (txShreg[WORD_W-1] == $past(txWord[WORD_W-1])));

  // R7: the marker only changes at the shared launch point
  a_r7_marker_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsLaunch) |-> $past(strb.launch));

endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SLOTS      = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int OUT_DLY    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bclkIn,
  input  logic                     fsyncIn,
  input  logic                     sdataIn,
  output logic                     sdataOut,
  output logic                     fsyncOut,
  output logic [$clog2(SLOTS)-1:0] slotIdx,
  input  logic                     txValid,
  output logic                     txReady,
  input  logic [WORD_W-1:0]        txData,
  output logic                     rxValid,
  input  logic                     rxReady,
  output logic [WORD_W-1:0]        rxData,
  output logic                     txUnderrun,
  output logic                     rxOverrun
);
  tdm_strobe_t       strb;
  logic [WORD_W-1:0] txWord, rxWord;
  logic              txAvail, txTake, rxPush, rxRoom;

  tdm_ctrl #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .sdataIn(sdataIn), .strb(strb), .slotIdx(slotIdx)
  );

  tdm_datapath #(.WORD_W(WORD_W), .OUT_DLY(OUT_DLY)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .txWord(txWord), .txAvail(txAvail), .txTake(txTake),
    .rxWord(rxWord), .rxPush(rxPush), .rxRoom(rxRoom),
    .sdataOut(sdataOut), .fsyncOut(fsyncOut),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun)
  );

  tdm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rst_n(rst_n),
    .inValid(txValid), .inReady(txReady), .inData(txData),
    .outValid(txAvail), .outReady(txTake), .outData(txWord)
  );

  tdm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rst_n(rst_n),
    .inValid(rxPush), .inReady(rxRoom), .inData(rxWord),
    .outValid(rxValid), .outReady(rxReady), .outData(rxData)
  );

endmodule

// File: tb/tdm_port_tb.sv
module tdm_port_tb;
  localparam int HALF = 8;   // system cycles per bit-clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclkIn = 1'b0, fsyncIn = 1'b0, sdataIn = 1'b0;
  logic        sdataOut, fsyncOut;
  logic [2:0]  slotIdx;
  logic        txValid, txReady, rxValid, rxReady;
  logic [31:0] txData, rxData;
  logic        txUnderrun, rxOverrun;

  int checks = 0;
  int errors = 0;

  logic [31:0] feedQ[$];
  logic [31:0] txExp[$];
  logic [31:0] rxExp[$];
  logic [31:0] rxWords [24];
  bit          hostRxEn = 1'b1;
  bit          started = 1'b0;
  int          bitPos = 0;
  int          slotPos = 0;
  logic [31:0] txAcc = '0;

  always #5 clk = ~clk;

  tdm_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .sdataIn(sdataIn), .sdataOut(sdataOut), .fsyncOut(fsyncOut),
    .slotIdx(slotIdx), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxReady(rxReady),
    .rxData(rxData), .txUnderrun(txUnderrun), .rxOverrun(rxOverrun)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // host feeder: transmit FIFO push side
  initial begin
    txValid = 1'b0;
    txData  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && feedQ.size() > 0) begin
        txValid = 1'b1;
        txData  = feedQ[0];
        if (txReady) void'(feedQ.pop_front());
      end else begin
        txValid = 1'b0;
      end
    end
  end

  // scoreboard monitor: receive FIFO pop side
  initial begin
    logic [31:0] expW;
    rxReady = 1'b0;
    forever begin
      @(negedge clk);
      rxReady = hostRxEn && rst_n;
      if (rxReady && rxValid) begin
        if (rxExp.size() > 0) begin
          expW = rxExp.pop_front();
          chk(rxData == expW, "R1 received word", rxData, expW);
        end else begin
          chk(1'b0, "R1/R6 unexpected received word", rxData, 32'h0);
        end
      end
    end
  end

  // one bit period: fall (drive inputs), sample outputs, rise
  task automatic doBit(input logic fs, input logic din);
    logic [31:0] expW;
    @(negedge clk);
    bclkIn = 1'b0; fsyncIn = fs; sdataIn = din;
    repeat (HALF - 1) @(negedge clk);
    if (started) begin
      txAcc = {txAcc[30:0], sdataOut};
      chk(fsyncOut == (slotPos == 0 && bitPos == 0), "R7 fsyncOut alignment",
          {31'd0, fsyncOut}, {31'd0, (slotPos == 0 && bitPos == 0)});
      chk(slotIdx == slotPos[2:0], "R3 slot position", {29'd0, slotIdx}, slotPos);
      bitPos++;
      if (bitPos == 32) begin
        expW = (txExp.size() > 0) ? txExp.pop_front() : 32'h0;
        chk(txAcc == expW, "R2/R4/R5 transmitted slot word", txAcc, expW);
        bitPos  = 0;
        slotPos = (slotPos + 1) % 8;
      end
    end
    @(negedge clk);
    bclkIn = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    if (fs) begin
      started = 1'b1; bitPos = 0; slotPos = 0;
    end
  endtask

  task automatic runStream(input int nFrames, input bit limitRx);
    int stored = 0;
    doBit(1'b1, 1'b0);  // frame sync ahead of the first slot
    for (int f = 0; f < nFrames; f++) begin
      for (int s = 0; s < 8; s++) begin
        for (int b = 31; b >= 0; b--)
          doBit((s == 7 && b == 0 && f < nFrames - 1), rxWords[f*8+s][b]);
        if (!limitRx || stored < 8) begin
          rxExp.push_back(rxWords[f*8+s]);
          stored++;
        end
      end
    end
    @(negedge clk);
    bclkIn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    bclkIn = 1'b0; fsyncIn = 1'b0; sdataIn = 1'b0;
    feedQ.delete(); txExp.delete(); rxExp.delete();
    started = 1'b0; bitPos = 0; slotPos = 0; hostRxEn = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic feed(input logic [31:0] w);
    feedQ.push_back(w);
    txExp.push_back(w);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R8: reset state
    chk(sdataOut == 1'b0, "R8 sdataOut reset", {31'd0, sdataOut}, 32'h0);
    chk(fsyncOut == 1'b0, "R8 fsyncOut reset", {31'd0, fsyncOut}, 32'h0);
    chk(slotIdx == 3'd0, "R8 slotIdx reset", {29'd0, slotIdx}, 32'h0);
    chk(rxValid == 1'b0, "R8 rxValid reset", {31'd0, rxValid}, 32'h0);
    chk(txReady == 1'b1, "R8 txReady reset", {31'd0, txReady}, 32'h1);
    chk({txUnderrun, rxOverrun} == 2'b00, "R8 flags reset",
        {30'd0, txUnderrun, rxOverrun}, 32'h0);

    // main traffic: 26 transmit words, three receive frames
    for (int i = 0; i < 8; i++) feed(32'h5555_5554);
    for (int i = 0; i < 8; i++) feed(32'hC0DE_0000 + 32'(i * 32'h1111));
    for (int i = 0; i < 10; i++) feed(32'h5555_5554);
    for (int i = 0; i < 8; i++) begin
      rxWords[i]      = 32'hAAAA_AAAA;
      rxWords[8 + i]  = 32'h8000_0001 ^ (32'(i) << 4);
      rxWords[16 + i] = 32'(i + 1) * 32'h1357_9BDF;
    end

    // R10: bits before any frame sync do nothing
    for (int i = 0; i < 40; i++) doBit(1'b0, i[0]);
    chk(rxValid == 1'b0, "R10 no receive push before sync", {31'd0, rxValid}, 32'h0);
    chk(sdataOut == 1'b0, "R10 sdataOut low before sync", {31'd0, sdataOut}, 32'h0);
    chk(txReady == 1'b0, "R10 no transmit pop before sync (FIFO still full)",
        {31'd0, txReady}, 32'h0);

    runStream(3, 1'b0);
    repeat (20) @(negedge clk);
    chk(rxExp.size() == 0, "R1 all received words delivered", rxExp.size(), 32'h0);
    chk(txUnderrun == 1'b0, "R5 no underrun with FIFO fed", {31'd0, txUnderrun}, 32'h0);
    chk(rxOverrun == 1'b0, "R6 no overrun while host reads", {31'd0, rxOverrun}, 32'h0);

    // R9: FIFO depth
    doReset();
    for (int i = 0; i < 8; i++) feedQ.push_back(32'h1000_0000 + 32'(i));
    repeat (20) @(negedge clk);
    chk(txReady == 1'b0, "R9 txReady low at 8 words", {31'd0, txReady}, 32'h0);
    feedQ.push_back(32'hDEAD_BEEF);
    repeat (20) @(negedge clk);
    chk(feedQ.size() == 1, "R9 ninth word not taken", feedQ.size(), 32'h1);

    // R5: underrun, three words for a whole frame
    doReset();
    feed(32'h1234_5678); feed(32'h8765_4321); feed(32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) rxWords[i] = 32'h0F0F_0000 + 32'(i);
    repeat (10) @(negedge clk);
    chk(txUnderrun == 1'b0, "R5 no underrun before frame", {31'd0, txUnderrun}, 32'h0);
    runStream(1, 1'b0);
    chk(txUnderrun == 1'b1, "R5 underrun flagged", {31'd0, txUnderrun}, 32'h1);
    repeat (50) @(negedge clk);
    chk(txUnderrun == 1'b1, "R5 underrun sticky", {31'd0, txUnderrun}, 32'h1);

    // R6: overrun with the host not reading
    doReset();
    hostRxEn = 1'b0;
    for (int i = 0; i < 16; i++) rxWords[i] = 32'h3C00_0000 + 32'(i * 7);
    runStream(2, 1'b1);
    chk(rxOverrun == 1'b1, "R6 overrun flagged", {31'd0, rxOverrun}, 32'h1);
    hostRxEn = 1'b1;
    repeat (40) @(negedge clk);
    chk(rxExp.size() == 0, "R6 stored words intact", rxExp.size(), 32'h0);
    chk(rxValid == 1'b0, "R6 dropped words absent", {31'd0, rxValid}, 32'h0);
    chk(rxOverrun == 1'b1, "R6 overrun sticky", {31'd0, rxOverrun}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule